// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a single-port synchronous SRAM with a pipelined command interface. Every control and address input is taken on a rising clock edge, and only on edges where the active-low clock enable is low. Three chip selects decide together whether a load cycle starts an access. A step input chooses between loading a fresh address and advancing a two-bit burst counter. The counter runs in linear or interleaved order, set by a static strap.

Reads return data in the cycle after the command edge. Write data follows the write command by one enabled edge, so the write pipeline has the same depth as the read latency. Reads and writes can then alternate with no idle cycle. A read that directly follows a write to the same word is served through a per-lane bypass.

The data bus is split into an input, an output and a drive enable, so the model can sit inside a larger chip. Memory depth and the number of byte lanes are parameters.

Top module: `sync_burst_sram`

## Requirements
- R1: A load cycle (`burst_step_i`=0) selects the device only when `sel_a_ni`=0, `sel_b_i`=1 and `sel_c_ni`=0. With any other combination, no access happens and `data_oe_o` is 0 in the following cycle.
- R2: On an edge with `clk_en_ni`=1, every register holds. `data_o`, `data_oe_o`, the burst position and any pending write stay unchanged. Write data is taken only at the next enabled edge.
- R3: A selected load cycle with `wr_ni`=1 is a read. In the cycle after that edge, `data_o` equals the stored word at `addr_i`.
- R4: A selected load cycle with `wr_ni`=0 is a write. The word on `data_i` is taken at the next enabled edge. Lane b is bits [9b+8:9b], with bit 9b+8 as its parity bit. Lane b is written only if `lane_wr_ni[b]` was 0 at the command edge.
- R5: With `order_il_i`=0, successive steps address offsets (a0+n) mod 4 in the two low address bits, where a0 is the loaded offset. The upper bits stay unchanged and the sequence wraps after four.
- R6: With `order_il_i`=1, step n addresses offset a0 XOR n.
- R7: A step cycle (`burst_step_i`=1) after a deselect or after reset starts no access. `data_oe_o` stays 0.
- R8: A step cycle keeps the direction of the burst that was loaded. `wr_ni` is ignored on step cycles.
- R9: `data_oe_o` is 1 only while `out_en_ni`=0 and the previous enabled edge accepted a read. It is 0 during a write data phase and after a deselect, whatever `out_en_ni` is.
- R10: A read issued on the edge right after a write command to the same address returns the new data in the enabled lanes and the old data in the other lanes.
- R11: While `rst_ni` is low, `data_oe_o` is 0 and no burst is active.
- R12: Read, write and read commands may be issued on consecutive enabled edges, and each returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high stalls every register |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| burst_step_i | input | 1 | 0 loads a new address, 1 steps the burst |
| wr_ni | input | 1 | 0 makes a load cycle a write |
| lane_wr_ni | input | NUM_LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| order_il_i | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| out_en_ni | input | 1 | Output enable, active low |
| data_i | input | 9*NUM_LANES | Write data, nine bits per lane |
| data_o | output | 9*NUM_LANES | Read data |
| data_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The assertions take for granted that the order strap does not change while a burst is in progress. They also assume that a write data phase is always followed by an enabled edge before its data is expected in memory. The bench changes `order_il_i` only between bursts, after a deselect cycle. It drives every input one time unit after the rising edge, so stall, step and select patterns are taken exactly at the intended edge. All reads target words the bench has written before, so the expected values never depend on uninitialised storage.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_ord_e;

  function automatic logic [BURST_W-1:0] burst_offs(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input burst_ord_e         ord
  );
    return (ord == ORD_INTERLEAVED) ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              sel_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  burst_ord_e        ord_i,
  output logic              acc_valid_o,
  output logic              acc_wr_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic              active_q, is_wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt;
  logic [ADDR_W-1:0] burst_addr;

  assign cnt_nxt    = cnt_q + 1'b1;
  assign burst_addr = {base_q[ADDR_W-1:BURST_W], burst_offs(base_q[BURST_W-1:0], cnt_nxt, ord_i)};

  always_comb begin
    if (step_i) begin
      acc_valid_o = active_q;
      acc_wr_o    = is_wr_q;
      acc_addr_o  = burst_addr;
    end else begin
      acc_valid_o = sel_i;
      acc_wr_o    = wr_req_i;
      acc_addr_o  = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      is_wr_q  <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (en_i) begin
      if (!step_i) begin
        active_q <= sel_i;
        if (sel_i) begin
          base_q  <= addr_i;
          cnt_q   <= '0;
          is_wr_q <= wr_req_i;
        end
      end else if (active_q) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  AST_STALL_HOLDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(active_q) && $stable(base_q)); // R2
  AST_CNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && step_i && active_q |=> cnt_q == ($past(cnt_q) + 2'd1)); // R5
  AST_STEP_IDLE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !active_q |-> !acc_valid_o); // R7
endmodule

// File: rtl/sbs_wr_pipe.sv
module sbs_wr_pipe #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 wr_cmd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LANES-1:0] lane_wr_ni,
  output logic                 pend_valid_o,
  output logic [ADDR_W-1:0]    pend_addr_o,
  output logic [NUM_LANES-1:0] pend_lane_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_o <= 1'b0;
      pend_addr_o  <= '0;
      pend_lane_no <= '1;
    end else if (en_i) begin
      pend_valid_o <= wr_cmd_i;
      if (wr_cmd_i) begin
        pend_addr_o  <= addr_i;
        pend_lane_no <= lane_wr_ni;
      end
    end
  end

  AST_PEND_HOLDS_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pend_valid_o) && $stable(pend_addr_o) && $stable(pend_lane_no)); // R2
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        rd_cmd_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  input  logic                        pend_valid_i,
  input  logic [ADDR_W-1:0]           pend_addr_i,
  input  logic [NUM_LANES-1:0]        pend_lane_ni,
  input  logic [NUM_LANES*LANE_W-1:0] wdata_i,
  output logic [NUM_LANES*LANE_W-1:0] rdata_o,
  output logic                        rd_valid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic hit;
  assign hit = pend_valid_i && (pend_addr_i == rd_addr_i);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_in, rd_q;
    logic              lane_wr;

    assign lane_in = wdata_i[g*LANE_W +: LANE_W];
    assign lane_wr = pend_valid_i && !pend_lane_ni[g];

    always_ff @(posedge clk_i) begin
      if (en_i && lane_wr) mem[pend_addr_i] <= lane_in;
    end

    // same-word read after write takes the bytes being written now
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              rd_q <= '0;
      else if (en_i && rd_cmd_i) rd_q <= (hit && lane_wr) ? lane_in : mem[rd_addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_valid_o <= 1'b0;
    else if (en_i) rd_valid_o <= rd_cmd_i;
  end

  AST_READ_HOLDS_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o) && $stable(rd_valid_o)); // R2
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clk_en_ni,
  input  logic                 sel_a_ni,
  input  logic                 sel_b_i,
  input  logic                 sel_c_ni,
  input  logic                 burst_step_i,
  input  logic                 wr_ni,
  input  logic [NUM_LANES-1:0] lane_wr_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 order_il_i,
  input  logic                 out_en_ni,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 data_oe_o
);
  logic              en, sel;
  logic              acc_valid, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [NUM_LANES-1:0] pend_lane_n;
  logic              rd_valid;

  assign en  = !clk_en_ni;
  assign sel = !sel_a_ni && sel_b_i && !sel_c_ni;

  sbs_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .step_i      (burst_step_i),
    .sel_i       (sel),
    .wr_req_i    (!wr_ni),
    .addr_i      (addr_i),
    .ord_i       (burst_ord_e'(order_il_i)),
    .acc_valid_o (acc_valid),
    .acc_wr_o    (acc_wr),
    .acc_addr_o  (acc_addr)
  );

  sbs_wr_pipe #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES)) i_wr_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .wr_cmd_i     (acc_valid && acc_wr),
    .addr_i       (acc_addr),
    .lane_wr_ni   (lane_wr_ni),
    .pend_valid_o (pend_valid),
    .pend_addr_o  (pend_addr),
    .pend_lane_no (pend_lane_n)
  );

  sbs_array #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES)) i_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .rd_cmd_i     (acc_valid && !acc_wr),
    .rd_addr_i    (acc_addr),
    .pend_valid_i (pend_valid),
    .pend_addr_i  (pend_addr),
    .pend_lane_ni (pend_lane_n),
    .wdata_i      (data_i),
    .rdata_o      (data_o),
    .rd_valid_o   (rd_valid)
  );

  assign data_oe_o = rd_valid && !out_en_ni;

  AST_NO_DRIVE_IN_WR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !pend_valid); // R9
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !burst_step_i && !sel |=> !data_oe_o); // R1
  AST_WR_CMD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && acc_valid && acc_wr |=> !data_oe_o && pend_valid); // R4
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !data_oe_o); // R11
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int DW = NL * 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clk_en_ni, sel_a_ni, sel_b_i, sel_c_ni, burst_step_i, wr_ni, order_il_i, out_en_ni;
  logic [NL-1:0] lane_wr_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] data_i, data_o;
  logic data_oe_o;

  logic [DW-1:0] ref_mem [1 << AW];
  int n_chk = 0, n_err = 0;

  sync_burst_sram #(.ADDR_W(AW), .NUM_LANES(NL)) i_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni),
    .sel_a_ni(sel_a_ni), .sel_b_i(sel_b_i), .sel_c_ni(sel_c_ni),
    .burst_step_i(burst_step_i), .wr_ni(wr_ni), .lane_wr_ni(lane_wr_ni),
    .addr_i(addr_i), .order_il_i(order_il_i), .out_en_ni(out_en_ni),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
    $finish;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                          input logic [NL-1:0] lane_n);
    logic [DW-1:0] r = old_w;
    for (int b = 0; b < NL; b++) if (!lane_n[b]) r[b*9 +: 9] = new_w[b*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int k);
    logic [DW-1:0] r;
    for (int b = 0; b < NL; b++) r[b*9 +: 9] = 9'(k * 37 + b * 101 + 5);
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic nop();
    clk_en_ni = 1'b0; burst_step_i = 1'b0;
    sel_a_ni = 1'b1; sel_b_i = 1'b0; sel_c_ni = 1'b1;
    wr_ni = 1'b1; lane_wr_ni = '1; data_i = '0;
  endtask

  task automatic load(input logic [AW-1:0] a, input bit wr, input logic [NL-1:0] lane_n);
    clk_en_ni = 1'b0; burst_step_i = 1'b0;
    sel_a_ni = 1'b0; sel_b_i = 1'b1; sel_c_ni = 1'b0;
    wr_ni = !wr; lane_wr_ni = lane_n; addr_i = a;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] lane_n);
    load(a, 1'b1, lane_n);
    cyc();
    chk("R9 no drive in write data phase", {35'd0, data_oe_o}, '0);
    nop(); data_i = d;
    cyc();
    ref_mem[a] = merge(ref_mem[a], d, lane_n);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input string req);
    load(a, 1'b0, '1);
    cyc();
    chk({req, " read drive"}, {35'd0, data_oe_o}, 1);
    chk({req, " read data"}, data_o, ref_mem[a]);
    nop();
    cyc();
  endtask

  task automatic t_reset();
    #35;
    chk("R11 oe low in reset", {35'd0, data_oe_o}, '0);
    @(posedge clk); #1 rst_ni = 1'b1;
    burst_step_i = 1'b1;  // step with no burst loaded
    cyc();
    chk("R7 step after reset starts nothing", {35'd0, data_oe_o}, '0);
    nop(); cyc();
  endtask

  task automatic t_basic();
    write_word(8'h10, pat(1), '0);
    read_word(8'h10, "R3");
    write_word(8'h10, pat(2), 4'b1010);  // lanes 0 and 2 only
    read_word(8'h10, "R4 lane mask");
    write_word(8'h11, pat(3), '0);
    read_word(8'h11, "R4");
  endtask

  task automatic t_deselect();
    for (int p = 0; p < 3; p++) begin
      load(8'h10, 1'b0, '1);
      cyc();
      chk("R1 selected read drives", {35'd0, data_oe_o}, 1);
      case (p)
        0: sel_a_ni = 1'b1;
        1: sel_b_i  = 1'b0;
        default: sel_c_ni = 1'b1;
      endcase
      cyc();
      chk("R1 deselect stops drive", {35'd0, data_oe_o}, '0);
      burst_step_i = 1'b1;
      cyc();
      chk("R7 step after deselect ignored", {35'd0, data_oe_o}, '0);
      nop();
    end
    cyc();
  endtask

  task automatic t_oe();
    load(8'h11, 1'b0, '1); out_en_ni = 1'b1;
    cyc();
    chk("R9 out enable high masks drive", {35'd0, data_oe_o}, '0);
    out_en_ni = 1'b0; #1;
    chk("R9 out enable low drives", {35'd0, data_oe_o}, 1);
    chk("R9 data", data_o, ref_mem[8'h11]);
    nop(); cyc();
  endtask

  task automatic t_burst_linear();
    order_il_i = 1'b0;
    load(8'h21, 1'b1, '0);
    cyc();
    burst_step_i = 1'b1; wr_ni = 1'b1;  // direction must stick to write
    for (int i = 0; i < 3; i++) begin
      data_i = pat(10 + i);
      cyc();
      chk("R8 write burst keeps bus quiet", {35'd0, data_oe_o}, '0);
    end
    nop(); data_i = pat(13);
    cyc();
    ref_mem[8'h21] = pat(10); ref_mem[8'h22] = pat(11);
    ref_mem[8'h23] = pat(12); ref_mem[8'h20] = pat(13);
    load(8'h22, 1'b0, '1);
    cyc();
    chk("R5 linear beat 0", data_o, ref_mem[8'h22]);
    burst_step_i = 1'b1;
    cyc(); chk("R5 linear beat 1", data_o, ref_mem[8'h23]);
    cyc(); chk("R5 linear beat 2 wrap", data_o, ref_mem[8'h20]);
    cyc(); chk("R8 linear beat 3", data_o, ref_mem[8'h21]);
    cyc(); chk("R5 linear beat 4 wraps to start", data_o, ref_mem[8'h22]);
    nop(); cyc();
  endtask

  task automatic t_burst_il();
    order_il_i = 1'b1;
    load(8'h21, 1'b0, '1);
    cyc(); chk("R6 interleaved beat 0", data_o, ref_mem[8'h21]);
    burst_step_i = 1'b1;
    cyc(); chk("R6 interleaved beat 1", data_o, ref_mem[8'h20]);
    cyc(); chk("R6 interleaved beat 2", data_o, ref_mem[8'h23]);
    cyc(); chk("R6 interleaved beat 3", data_o, ref_mem[8'h22]);
    nop(); cyc();
    order_il_i = 1'b0;
  endtask

  task automatic t_stall();
    load(8'h20, 1'b0, '1);
    cyc();
    chk("R2 read before stall", data_o, ref_mem[8'h20]);
    clk_en_ni = 1'b1; addr_i = 8'h11; wr_ni = 1'b0; sel_a_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R2 data held in stall", data_o, ref_mem[8'h20]);
      chk("R2 drive held in stall", {35'd0, data_oe_o}, 1);
    end
    clk_en_ni = 1'b0; burst_step_i = 1'b1; wr_ni = 1'b1;
    cyc();
    chk("R2 burst resumes after stall", data_o, ref_mem[8'h21]);
    nop(); cyc();
    load(8'h30, 1'b1, '0);
    cyc();
    clk_en_ni = 1'b1; data_i = pat(40);
    cyc(); cyc();
    nop(); data_i = pat(41);
    cyc();
    ref_mem[8'h30] = pat(41);
    read_word(8'h30, "R2 write data after stall");
  endtask

  task automatic t_bypass();
    write_word(8'h40, pat(50), '0);
    load(8'h40, 1'b1, 4'b0101);  // lanes 1 and 3
    cyc();
    load(8'h40, 1'b0, '1); data_i = pat(51);
    cyc();
    ref_mem[8'h40] = merge(ref_mem[8'h40], pat(51), 4'b0101);
    chk("R10 bypass merged data", data_o, ref_mem[8'h40]);
    chk("R10 bypass drives", {35'd0, data_oe_o}, 1);
    load(8'h41, 1'b1, '0);
    cyc();
    chk("R12 write after read quiet", {35'd0, data_oe_o}, '0);
    load(8'h41, 1'b0, '1); data_i = pat(52);
    cyc();
    ref_mem[8'h41] = pat(52);
    chk("R12 read after write", data_o, ref_mem[8'h41]);
    nop(); cyc();
    read_word(8'h40, "R10 merged word stored");
  endtask

  initial begin
    order_il_i = 1'b0; out_en_ni = 1'b0; addr_i = '0;
    nop();
    t_reset();
    t_basic();
    t_deselect();
    t_oe();
    t_burst_linear();
    t_burst_il();
    t_stall();
    t_bypass();
    report();
    $finish;
  end
endmodule